// File: doc/BRIEF.md
# Capture/Reload Timer with Serial Clock Output

This block is a 16-bit timer/counter controlled through an 8-bit control register on a simple byte-wide register port. It increments either on a qualified timer tick or on falling edges of an external count pin. Its one falling-edge trigger pin either snapshots the counter into a 16-bit capture/reload register or reloads the counter from that register. Which action happens depends on the mode.

When either serial clock select bit is set, the block acts as a baud generator. It always auto-reloads on overflow, ignores the trigger pin, and does not raise its overflow flag. Its overflow pulse feeds the serial receive or transmit clock. A level interrupt request combines the overflow and external flags. The external flag is masked while the up/down mode input is high. Software clears both flags by writing the control register.

Top module: `cr_timer`

## Requirements
- R1: After reset, the control register, counter and capture/reload register read 0, and `irq_o` and `ovf_pulse_o` are low.
- R2: The control register is at address 0. Its bits, MSB to LSB, are: 7 overflow flag, 6 external flag, 5 rx clock select, 4 tx clock select, 3 external enable, 2 run, 1 count-pin mode, 0 capture mode. The counter is at addresses 1 (low byte) and 2 (high byte). The capture/reload register is at 3 (low) and 4 (high). Every register reads back what was written.
- R3: With run=1 and count-pin mode=0, the counter increments once for each cycle in which `tick_i` is high. With run=0 it holds.
- R4: With count-pin mode=1, the counter increments once per falling edge of `cnt_pin_i`, whatever the low time, and `tick_i` is ignored.
- R5: In capture mode without a clock select, an overflow wraps the counter to 0, sets the overflow flag, and pulses `ovf_pulse_o` for one cycle.
- R6: In reload mode (bit 0 = 0), an overflow loads the counter from the capture/reload register, so the overflow period is 65536 minus the reload value in ticks.
- R7: In capture mode with external enable=1 and no clock select, a falling edge on `trig_pin_i` copies the counter into the capture/reload register and sets the external flag. With external enable=0, the edge changes nothing.
- R8: In reload mode with external enable=1 and no clock select, a trigger falling edge loads the counter from the capture/reload register and sets the external flag.
- R9: When either clock select bit is 1, overflows auto-reload regardless of bit 0. `ovf_pulse_o` still pulses, but the overflow flag stays 0. Trigger edges neither capture, reload, nor set the external flag.
- R10: Once set, the flags stay set until software writes the control register with them at 0.
- R11: `irq_o` equals overflow flag OR (external flag AND NOT `updown_i`).
- R12: `rx_clk_sel_o` and `tx_clk_sel_o` follow control bits 5 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timer tick enable |
| cnt_pin_i | input | 1 | External count pin, asynchronous |
| trig_pin_i | input | 1 | External trigger pin, asynchronous |
| updown_i | input | 1 | Up/down mode; masks external flag interrupt |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| ovf_pulse_o | output | 1 | One-cycle pulse per counter overflow |
| rx_clk_sel_o | output | 1 | Serial rx clock taken from this block |
| tx_clk_sel_o | output | 1 | Serial tx clock taken from this block |
| irq_o | output | 1 | Level interrupt request |

## Verification
The assertions assume that software does not write a counter or capture byte in the same cycle as a trigger edge or overflow that targets it. They also assume the pins are synchronized, so an edge shows up as a single-cycle detection. The stimulus changes pins and bus signals only on falling clock edges. It performs register writes only while counting is stopped or ticks are off, and it spaces pin pulses several cycles apart. The sweeps cover every combination of the trigger-related control bits and several reload values in each counting mode.

// File: rtl/cr_timer_pkg.sv
package cr_timer_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic ovf_flag;
    logic ext_flag;
    logic rx_sel;
    logic tx_sel;
    logic ext_en;
    logic run;
    logic cnt_mode;
    logic cap_mode;
  } ctrl_t;
endpackage

// File: rtl/cr_timer_sync.sv
module cr_timer_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic din_i,
  output logic fall_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], din_i};
  end

  assign fall_o = sh_q[STAGES] & ~sh_q[STAGES-1];

  // R4
  one_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/cr_timer_ctrl.sv
module cr_timer_ctrl
  import cr_timer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              ovf_set_i,
  input  logic              ext_set_i,
  output ctrl_t             ctrl_o
);
  ctrl_t ctrl_q, ctrl_d;

  // hardware flag set wins over a same-cycle software write
  always_comb begin
    ctrl_d = we_i ? ctrl_t'(wdata_i) : ctrl_q;
    if (ovf_set_i) ctrl_d.ovf_flag = 1'b1;
    if (ext_set_i) ctrl_d.ext_flag = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else         ctrl_q <= ctrl_d;
  end

  assign ctrl_o = ctrl_q;

  // R10
  ovf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> !$fell(ctrl_q.ovf_flag));
  // R10
  ext_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> !$fell(ctrl_q.ext_flag));
  // R9
  baud_no_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.rx_sel || ctrl_q.tx_sel) && !we_i |=> !$rose(ctrl_q.ovf_flag));
endmodule

// File: rtl/cr_timer_core.sv
module cr_timer_core
  import cr_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int NB   = CNT_W / BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              cnt_fall_i,
  input  logic              trig_fall_i,
  input  logic              run_i,
  input  logic              cnt_mode_i,
  input  logic              ext_en_i,
  input  logic              cap_mode_i,
  input  logic              baud_i,
  input  logic [NB-1:0]     cnt_we_i,
  input  logic [NB-1:0]     cap_we_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  cap_o,
  output logic              ovf_set_o,
  output logic              ext_set_o,
  output logic              ovf_pulse_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, cap_q, cap_d;
  logic inc, ovf_evt, trig_act, do_cap, do_ld, pulse_q;

  assign inc      = run_i & (cnt_mode_i ? cnt_fall_i : tick_i);
  assign ovf_evt  = inc & (cnt_q == '1);
  assign trig_act = trig_fall_i & ext_en_i & ~baud_i;
  assign do_cap   = trig_act & cap_mode_i;
  assign do_ld    = (ovf_evt & (baud_i | ~cap_mode_i)) | (trig_act & ~cap_mode_i);

  always_comb begin
    cnt_d = cnt_q;
    if (do_ld)    cnt_d = cap_q;
    else if (inc) cnt_d = cnt_q + 1'b1;
    cap_d = cap_q;
    if (do_cap)   cap_d = cnt_q;
    for (int b = 0; b < NB; b++) begin
      if (cnt_we_i[b]) cnt_d[b*BYTE_W +: BYTE_W] = wdata_i;
      if (cap_we_i[b]) cap_d[b*BYTE_W +: BYTE_W] = wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      cap_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      cap_q   <= cap_d;
      pulse_q <= ovf_evt;
    end
  end

  assign cnt_o       = cnt_q;
  assign cap_o       = cap_q;
  assign ovf_set_o   = ovf_evt & ~baud_i;
  assign ext_set_o   = trig_act;
  assign ovf_pulse_o = pulse_q;

  // R3
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i && cnt_we_i == '0 && !(trig_fall_i && ext_en_i) |=> $stable(cnt_q));
  // R7
  cap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_we_i == '0 && !(trig_fall_i && ext_en_i && cap_mode_i) |=> $stable(cap_q));
  // R9
  baud_no_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    baud_i && cap_we_i == '0 |=> $stable(cap_q));
endmodule

// File: rtl/cr_timer.sv
module cr_timer
  import cr_timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              cnt_pin_i,
  input  logic              trig_pin_i,
  input  logic              updown_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              ovf_pulse_o,
  output logic              rx_clk_sel_o,
  output logic              tx_clk_sel_o,
  output logic              irq_o
);
  localparam int NB = CNT_W / BYTE_W;

  ctrl_t            ctrl;
  logic             cnt_fall, trig_fall, ovf_set, ext_set, ctrl_we;
  logic [NB-1:0]    cnt_we, cap_we;
  logic [CNT_W-1:0] cnt, cap;

  assign ctrl_we = wr_en_i && (addr_i == '0);

  for (genvar b = 0; b < NB; b++) begin : g_we
    assign cnt_we[b] = wr_en_i && (addr_i == ADDR_W'(1 + b));
    assign cap_we[b] = wr_en_i && (addr_i == ADDR_W'(1 + NB + b));
  end

  cr_timer_sync #(.STAGES(SYNC_STAGES)) u_cnt_sync (
    .clk_i, .rst_ni, .din_i(cnt_pin_i), .fall_o(cnt_fall));

  cr_timer_sync #(.STAGES(SYNC_STAGES)) u_trig_sync (
    .clk_i, .rst_ni, .din_i(trig_pin_i), .fall_o(trig_fall));

  cr_timer_ctrl u_ctrl (
    .clk_i, .rst_ni, .we_i(ctrl_we), .wdata_i,
    .ovf_set_i(ovf_set), .ext_set_i(ext_set), .ctrl_o(ctrl));

  cr_timer_core #(.CNT_W(CNT_W)) u_core (
    .clk_i, .rst_ni, .tick_i,
    .cnt_fall_i(cnt_fall), .trig_fall_i(trig_fall),
    .run_i(ctrl.run), .cnt_mode_i(ctrl.cnt_mode), .ext_en_i(ctrl.ext_en),
    .cap_mode_i(ctrl.cap_mode), .baud_i(ctrl.rx_sel | ctrl.tx_sel),
    .cnt_we_i(cnt_we), .cap_we_i(cap_we), .wdata_i,
    .cnt_o(cnt), .cap_o(cap), .ovf_set_o(ovf_set), .ext_set_o(ext_set),
    .ovf_pulse_o);

  always_comb begin
    rdata_o = '0;
    if (addr_i == '0) rdata_o = ctrl;
    for (int b = 0; b < NB; b++) begin
      if (addr_i == ADDR_W'(1 + b))      rdata_o = cnt[b*BYTE_W +: BYTE_W];
      if (addr_i == ADDR_W'(1 + NB + b)) rdata_o = cap[b*BYTE_W +: BYTE_W];
    end
  end

  assign rx_clk_sel_o = ctrl.rx_sel;
  assign tx_clk_sel_o = ctrl.tx_sel;
  assign irq_o        = ctrl.ovf_flag | (ctrl.ext_flag & ~updown_i);

  // R11
  updown_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    updown_i && !ctrl.ovf_flag |-> !irq_o);
endmodule

// File: tb/cr_timer_bench.sv
`timescale 1ns/1ps
module cr_timer_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b0, cnt_pin = 1'b1, trig_pin = 1'b1, updown = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic ovf_pulse, rx_sel, tx_sel, irq;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  cr_timer u_cr_timer (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .cnt_pin_i(cnt_pin),
    .trig_pin_i(trig_pin), .updown_i(updown), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .ovf_pulse_o(ovf_pulse), .rx_clk_sel_o(rx_sel), .tx_clk_sel_o(tx_sel),
    .irq_o(irq));

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int d);
    @(negedge clk); addr = a; #1 d = int'(rdata);
  endtask

  task automatic rd16(input logic [2:0] a, output int d);
    int lo, hi;
    rd(a, lo); rd(a + 3'd1, hi);
    d = (hi << 8) | lo;
  endtask

  task automatic wr16(input logic [2:0] a, input int d);
    wr(a, 8'(d)); wr(a + 3'd1, 8'(d >> 8));
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    int v, c, p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v); check("R1 reg", v, 0);
    end
    check("R1 irq", int'(irq), 0);
    check("R1 pulse", int'(ovf_pulse), 0);

    // R2 register map and readback, R11 flag drives irq
    wr(3'd0, 8'hA1); rd(3'd0, v); check("R2 ctrl", v, 'hA1);
    check("R11 ovf irq", int'(irq), 1);
    wr(3'd0, 8'h00);
    wr16(3'd1, 'h5AC3); rd16(3'd1, v); check("R2 cnt", v, 'h5AC3);
    wr16(3'd3, 'h3C96); rd16(3'd3, v); check("R2 cap", v, 'h3C96);

    // R3 tick counting then hold
    wr16(3'd1, 0); wr(3'd0, 8'h04);
    @(negedge clk); tick = 1'b1;
    repeat (37) @(negedge clk);
    tick = 1'b0;
    rd16(3'd1, v); check("R3 count", v, 37);
    wr(3'd0, 8'h00);
    @(negedge clk); tick = 1'b1;
    repeat (20) @(negedge clk);
    tick = 1'b0;
    rd16(3'd1, v); check("R3 hold", v, 37);

    // R4 count pin edges, tick ignored
    wr16(3'd1, 0); wr(3'd0, 8'h06);
    @(negedge clk); tick = 1'b1;
    for (int i = 0; i < 9; i++) begin
      cnt_pin = 1'b0; repeat ((i % 4) + 1) @(negedge clk);
      cnt_pin = 1'b1; repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    tick = 1'b0;
    rd16(3'd1, v); check("R4 edges", v, 9);

    // R5 R6 R9 R12 overflow sweep
    for (int m = 0; m < 4; m++) begin
      for (int k = 0; k < 3; k++) begin
        int cv, exp_p, exp_c, pulses, ctl, baud;
        cv  = (k == 0) ? 'hFFFF : (k == 1) ? 'hFFF0 : 'hFF00;
        ctl = (m == 0) ? 'h04 : (m == 1) ? 'h05 : (m == 2) ? 'h25 : 'h14;
        baud = (m >= 2);
        p = 65536 - cv;
        if (m == 1) begin
          exp_p = (cv + 1000) >> 16; exp_c = (cv + 1000) & 'hFFFF;
        end else begin
          exp_p = 1000 / p; exp_c = cv + (1000 % p);
        end
        wr(3'd0, 8'h00); wr16(3'd3, cv); wr16(3'd1, cv); wr(3'd0, 8'(ctl));
        tick = 1'b1; pulses = 0;
        repeat (1000) begin
          @(negedge clk); if (ovf_pulse) pulses++;
        end
        tick = 1'b0;
        c = (m == 1) ? 5 : (m == 0) ? 6 : 9;
        check(m == 1 ? "R5 pulses" : baud ? "R9 pulses" : "R6 pulses", pulses, exp_p);
        rd16(3'd1, v);
        check(m == 1 ? "R5 cnt" : baud ? "R9 cnt" : "R6 cnt", v, exp_c);
        rd(3'd0, v);
        check(baud ? "R9 ovf flag" : "R5 ovf flag", (v >> 7) & 1, (!baud && exp_p > 0) ? 1 : 0);
        check("R12 rx sel", int'(rx_sel), (m == 2) ? 1 : 0);
        check("R12 tx sel", int'(tx_sel), (m == 3) ? 1 : 0);
        if (c == 0) $display("unused");
      end
    end

    // R7 R8 R9 R10 R11 trigger sweep over ext_en, cap_mode, rx, tx
    for (int i = 0; i < 16; i++) begin
      int en, cm, rx, tx, act, ctl, exp_cnt, exp_cap;
      en = i & 1; cm = (i >> 1) & 1; rx = (i >> 2) & 1; tx = (i >> 3) & 1;
      ctl = (rx << 5) | (tx << 4) | (en << 3) | cm;
      act = en && !rx && !tx;
      exp_cnt = (act && !cm) ? 'hABCD : 'h1234;
      exp_cap = (act && cm)  ? 'h1234 : 'hABCD;
      wr(3'd0, 8'h00); wr16(3'd1, 'h1234); wr16(3'd3, 'hABCD); wr(3'd0, 8'(ctl));
      trig_pin = 1'b0; repeat (5) @(negedge clk);
      trig_pin = 1'b1; repeat (5) @(negedge clk);
      rd16(3'd1, v); check(cm ? "R7 cnt" : "R8 cnt", v, exp_cnt);
      rd16(3'd3, v); check(cm ? "R7 cap" : "R8 cap", v, exp_cap);
      rd(3'd0, v);
      check(act ? (cm ? "R7 ext flag" : "R8 ext flag") : "R9 ext flag", (v >> 6) & 1, act);
      check("R12 rx", int'(rx_sel), rx);
      check("R12 tx", int'(tx_sel), tx);
      updown = 1'b1; @(negedge clk); check("R11 masked", int'(irq), 0);
      updown = 1'b0; @(negedge clk); check("R11 unmasked", int'(irq), act);
      repeat (10) @(negedge clk);
      rd(3'd0, v); check("R10 flag held", (v >> 6) & 1, act);
    end

    // R10 software clear
    wr(3'd0, 8'h08); rd(3'd0, v); check("R10 cleared", (v >> 6) & 3, 0);
    check("R10 irq low", int'(irq), 0);

    finish_run();
  end
endmodule